// File: doc/BRIEF.md
# Dual-Width Parallel Register Write Port

This block is the device-side write port of a peripheral sitting on a 12-bit asynchronous parallel bus. A host writes either a 12-bit control register or an 8-bit shadow register. Each write is a pulse of an active-low write strobe while an active-low select is held low. The two strobes are merged and synchronised into the system clock. Bus data is captured when the merged strobe is seen to rise.

A static mode input picks the bus width. In full-width mode, one write loads all twelve control bits. In narrow mode, only bus bits 7:0 carry data and bus bit 8 is reused to mark the upper half. The control word is then built from a lower write followed by an upper write. An upper write that arrives out of order, or that carries a non-zero top nibble, is refused and raises a sticky error flag. Each register gives a one-cycle pulse in the cycle its new value appears.

Top module: `pbus_reg_writer`

## Requirements
- R1: While `rst_n` is low and after its release, `ctrl_q`, `shadow_q` and `seq_err` are 0, no byte is pending, and neither update pulse is high.
- R2: With `word_mode`=1 and `tgt_shadow`=0, one write copies all twelve bits of `din` into `ctrl_q`, with `din[8]` treated as ordinary data.
- R3: With `word_mode`=0 and `tgt_shadow`=0, a write with `din[8]`=0 stores `din[7:0]` as the pending lower byte. `ctrl_q` does not change and no pulse is given.
- R4: With `word_mode`=0, a write with `din[8]`=1, a pending lower byte and `din[7:4]`=0 loads `ctrl_q` with `{din[3:0], pending byte}`. It pulses `ctrl_upd` and clears the pending byte.
- R5: In narrow mode, an upper write (`din[8]`=1) with no pending lower byte leaves `ctrl_q` unchanged and sets `seq_err`.
- R6: In narrow mode, an upper write whose `din[7:4]` is not zero leaves `ctrl_q` unchanged, sets `seq_err` and discards the pending lower byte.
- R7: With `tgt_shadow`=1, a single write loads `din[7:0]` into `shadow_q` in either mode, whatever the value of `din[8]`. It pulses `shadow_upd` and leaves `ctrl_q` and any pending lower byte untouched.
- R8: A write takes effect only on the rising edge of the merged strobe (`sel_n` OR `wstb_n`). Toggling `wstb_n` while `sel_n` is high has no effect. Driving `sel_n` and `wstb_n` as one signal gives a valid write.
- R9: Any change of `word_mode` discards a pending lower byte.
- R10: `ctrl_upd` and `shadow_upd` are each high for exactly one cycle per accepted write. A register changes only in a cycle where its pulse is high.
- R11: `seq_err` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low device select |
| wstb_n | input | 1 | Active-low write strobe |
| word_mode | input | 1 | 1: full 12-bit writes, 0: two 8-bit writes |
| tgt_shadow | input | 1 | 1: shadow register, 0: control register |
| din | input | 12 | Bus data; bit 8 marks the upper byte in narrow mode |
| ctrl_q | output | 12 | Control register contents |
| shadow_q | output | 8 | Shadow register contents |
| ctrl_upd | output | 1 | One-cycle pulse when `ctrl_q` takes a new value |
| shadow_upd | output | 1 | One-cycle pulse when `shadow_q` takes a new value |
| seq_err | output | 1 | Sticky flag for a refused upper byte |

## Verification
The assertions assume that `din`, `tgt_shadow` and `word_mode` are held stable from before the merged strobe rises until at least four clocks after it. They also assume that each strobe low time and high time spans several clocks, so the synchroniser never merges two writes. The bench drives the bus at the falling clock edge. It keeps data valid for six clocks after each release of the strobe, and leaves idle gaps between writes. It changes `word_mode` only while the strobe is idle.

// File: rtl/pbus_reg_writer.sv
module pbus_reg_writer #(
  parameter int CW = 12,
  parameter int SW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wstb_n,
  input  logic          word_mode,
  input  logic          tgt_shadow,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] ctrl_q,
  output logic [SW-1:0] shadow_q,
  output logic          ctrl_upd,
  output logic          shadow_upd,
  output logic          seq_err
);
  localparam int HW = CW - BW;

  logic [2:0]    sync;
  logic          rise;
  logic          mode_q;
  logic          pend_vld;
  logic [BW-1:0] pend;
  logic          hi_sel;
  logic          hi_ok;

  assign rise   = sync[1] & ~sync[2];
  assign hi_sel = din[BW];
  assign hi_ok  = pend_vld && (din[BW-1:HW] == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '1;
    else        sync <= {sync[1:0], sel_n | wstb_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= 1'b1;
    else        mode_q <= word_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      shadow_q   <= '0;
      ctrl_upd   <= 1'b0;
      shadow_upd <= 1'b0;
      seq_err    <= 1'b0;
      pend_vld   <= 1'b0;
      pend       <= '0;
    end else begin
      ctrl_upd   <= 1'b0;
      shadow_upd <= 1'b0;
      if (rise && tgt_shadow) begin
        shadow_q   <= din[SW-1:0];
        shadow_upd <= 1'b1;
      end else if (rise && word_mode) begin
        ctrl_q   <= din;
        ctrl_upd <= 1'b1;
        pend_vld <= 1'b0;
      end else if (rise && !hi_sel) begin
        pend     <= din[BW-1:0];
        pend_vld <= 1'b1;
      end else if (rise && hi_ok) begin
        ctrl_q   <= {din[HW-1:0], pend};
        ctrl_upd <= 1'b1;
        pend_vld <= 1'b0;
      end else if (rise) begin
        seq_err  <= 1'b1;
        pend_vld <= 1'b0;
      end
      if (word_mode != mode_q) pend_vld <= 1'b0;
    end
  end

  p_ctrl_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd |=> !ctrl_upd);
  p_shadow_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_upd |=> !shadow_upd);
  p_ctrl_change_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> ctrl_upd);
  p_shadow_change_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q != $past(shadow_q)) |-> shadow_upd);
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_upd && shadow_upd));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  p_mode_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode != mode_q) |=> !pend_vld);
  p_upd_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_upd || shadow_upd) |-> $past(sync[1]));
  p_byte_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_upd && !word_mode && !$past(word_mode)) |-> (ctrl_q[CW-1:CW-HW] == $past(din[HW-1:0])));
endmodule

// File: tb/test_pbus_reg_writer.sv
module test_pbus_reg_writer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, wstb_n = 1'b1, word_mode = 1'b1, tgt_shadow = 1'b0;
  logic [11:0] din = '0;
  logic [11:0] ctrl_q;
  logic [7:0]  shadow_q;
  logic ctrl_upd, shadow_upd, seq_err;
  int checks = 0, errors = 0;
  int n_cu = 0, n_su = 0, wide = 0;
  logic cu_d = 1'b0, su_d = 1'b0;

  always #2 clk = ~clk;

  pbus_reg_writer i_pbus_reg_writer (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n),
    .word_mode(word_mode), .tgt_shadow(tgt_shadow), .din(din),
    .ctrl_q(ctrl_q), .shadow_q(shadow_q), .ctrl_upd(ctrl_upd),
    .shadow_upd(shadow_upd), .seq_err(seq_err));

  always @(posedge clk) begin
    if (ctrl_upd) n_cu++;
    if (shadow_upd) n_su++;
    if ((ctrl_upd && cu_d) || (shadow_upd && su_d)) wide++;
    cu_d <= ctrl_upd;
    su_d <= shadow_upd;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(2);
  endtask

  task automatic bus_write(logic mode, logic tgt, logic [11:0] d, bit tied);
    @(negedge clk);
    word_mode = mode; tgt_shadow = tgt; din = d;
    idle(1);
    sel_n = 1'b0; wstb_n = 1'b0;
    idle(3);
    wstb_n = 1'b1;
    if (tied) sel_n = 1'b1;
    idle(6);
    sel_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ctrl", ctrl_q, 0); chk("R1 shadow", shadow_q, 0);
    chk("R1 err", seq_err, 0); chk("R1 pulses", n_cu + n_su, 0);
  endtask

  task automatic t_word();
    int c0 = n_cu;
    bus_write(1'b1, 1'b0, 12'hB5A, 1'b0);
    chk("R2 ctrl", ctrl_q, 12'hB5A); chk("R2 pulse", n_cu - c0, 1);
    bus_write(1'b1, 1'b0, 12'h100, 1'b0);
    chk("R2 bit8 data", ctrl_q, 12'h100);
  endtask

  task automatic t_byte_pair();
    int c0 = n_cu;
    bus_write(1'b0, 1'b0, 12'h03C, 1'b0);
    chk("R3 ctrl held", ctrl_q, 12'h100); chk("R3 no pulse", n_cu - c0, 0);
    bus_write(1'b0, 1'b0, 12'h10A, 1'b0);
    chk("R4 ctrl", ctrl_q, 12'hA3C); chk("R4 pulse", n_cu - c0, 1);
  endtask

  task automatic t_shadow();
    int c0 = n_cu, s0 = n_su;
    bus_write(1'b1, 1'b1, 12'hE77, 1'b0);
    chk("R7 shadow word", shadow_q, 8'h77);
    bus_write(1'b0, 1'b0, 12'h0C4, 1'b0);
    bus_write(1'b0, 1'b1, 12'h19E, 1'b0);
    chk("R7 shadow byte", shadow_q, 8'h9E); chk("R7 spulses", n_su - s0, 2);
    bus_write(1'b0, 1'b0, 12'h105, 1'b0);
    chk("R7 pending kept", ctrl_q, 12'h5C4); chk("R7 cpulses", n_cu - c0, 1);
  endtask

  task automatic t_strobe();
    int c0 = n_cu;
    @(negedge clk); word_mode = 1'b1; tgt_shadow = 1'b0; din = 12'h321;
    idle(2); wstb_n = 1'b0; idle(3); wstb_n = 1'b1; idle(6);
    chk("R8 no select", ctrl_q, 12'h5C4); chk("R8 no pulse", n_cu - c0, 0);
    bus_write(1'b1, 1'b0, 12'h7E1, 1'b1);
    chk("R8 tied strobes", ctrl_q, 12'h7E1);
  endtask

  task automatic t_mode_change();
    bus_write(1'b0, 1'b0, 12'h055, 1'b0);
    @(negedge clk); word_mode = 1'b1; idle(3); word_mode = 1'b0; idle(3);
    bus_write(1'b0, 1'b0, 12'h102, 1'b0);
    chk("R9 ctrl held", ctrl_q, 12'h7E1); chk("R9 err", seq_err, 1);
    idle(10);
    chk("R11 sticky", seq_err, 1);
  endtask

  task automatic t_bad_nibble();
    do_reset();
    bus_write(1'b0, 1'b0, 12'h0AA, 1'b0);
    bus_write(1'b0, 1'b0, 12'h131, 1'b0);
    chk("R6 ctrl held", ctrl_q, 0); chk("R6 err", seq_err, 1);
    bus_write(1'b0, 1'b0, 12'h101, 1'b0);
    chk("R6 pending gone", ctrl_q, 0);
  endtask

  task automatic t_orphan_high();
    do_reset();
    chk("R11 cleared", seq_err, 0);
    bus_write(1'b0, 1'b0, 12'h10F, 1'b0);
    chk("R5 ctrl held", ctrl_q, 0); chk("R5 err", seq_err, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_word(); t_byte_pair(); t_shadow(); t_strobe();
        t_mode_change(); t_bad_nibble(); t_orphan_high();
        chk("R10 pulse width", wide, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule